// File: doc/BRIEF.md
# H-Bridge Gate Controller with Qualified Fault Shutdown

This block is the digital core of a two-leg DC-motor bridge driver. Two control bits select one of four bridge modes: drive in one direction, drive in the other, brake through both sink switches, or float with every switch open. The block turns that choice into four gate enables, one source (high-side) and one sink (low-side) per leg. Each leg passes through a dead-time state machine, so that the two switches of a leg can never conduct at the same time.

Digital fault indications come from external comparators. They are: overcurrent on each of the four switches, a short across the load, an open-load comparator pair, overtemperature, and two undervoltage levels. Each latched fault is watched only in the modes where it can show up. It must persist for a programmable number of clock cycles before it counts. Once it counts, all gates drop in the same cycle as the active-low error flag goes down. The flag is also offered as an open-drain pull-down enable. Most latched faults are released by moving the control bits to a mode where they cannot be observed. A load short stays latched until undervoltage or reset. Overtemperature and undervoltage act as levels and recover on their own.

Top module: `hbridge_ctrl`

## Requirements
- R1: The control pair {ctl_a, ctl_b} selects the bridge mode. 00 turns on source of leg 0 and sink of leg 1. 01 turns on sink of leg 0 and source of leg 1. 10 turns on both sinks. 11 turns off all four switches. gate_src[i] and gate_snk[i] belong to leg i.
- R2: Source and sink of one leg are never on together. A leg leaving the off state turns its new switch on DEAD_CYC+1 clock edges after the control change. A leg reversing directly from one switch to the other needs DEAD_CYC+2 edges. A leg whose command is unchanged keeps its switch on.
- R3: A latched fault input must be high and watched on QUAL_CYC consecutive clock edges before it latches. Any gap restarts the count, so shorter pulses have no effect.
- R4: When a fault latches, every gate goes to 0 and err_n goes to 0 in the same cycle, with err_od = 1 (err_n is always the complement of err_od).
- R5: Each switch's overcurrent input is watched only while that switch is commanded on. Its latch clears on the edge where the control pair changes to a mode that does not command that switch. A change to a mode that still commands it leaves the latch set.
- R6: load_short is watched in modes 00 and 01. Its latch survives any control change. It clears only on reset or on uv_off.
- R7: The open-load check is watched only in mode 11 and needs open_hi and open_lo both high. It clears on a change to any other mode.
- R8: While over_temp is high, all gates are 0 and err_n is 0 without delay. When it falls, the flag releases and the commanded mode returns through the dead-time sequence.
- R9: After reset no gate turns on until uv_on has been seen. uv_off turns every gate off from the next cycle and holds err_n low until a later uv_on. When uv_on and uv_off are high together, uv_off wins.
- R10: Synchronous reset leaves all gates 0, err_n 1 and every fault latch and counter clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_a | input | 1 | Control bit A (mode MSB) |
| ctl_b | input | 1 | Control bit B (mode LSB) |
| oc_src | input | 2 | Overcurrent comparator per source switch, bit i = leg i |
| oc_snk | input | 2 | Overcurrent comparator per sink switch, bit i = leg i |
| load_short | input | 1 | Short across the load |
| open_hi | input | 1 | Open-load comparator: leg 0 pulled high |
| open_lo | input | 1 | Open-load comparator: leg 1 pulled low |
| over_temp | input | 1 | Overtemperature level |
| uv_on | input | 1 | Supply rose above the switch-on level |
| uv_off | input | 1 | Supply fell below the switch-off level |
| gate_src | output | 2 | Source switch enables, bit i = leg i |
| gate_snk | output | 2 | Sink switch enables, bit i = leg i |
| err_od | output | 1 | Open-drain pull-down enable for the error flag |
| err_n | output | 1 | Error flag, 0 = fault |

## Verification
The assertions assume the fault and supply inputs are synchronous levels that change only between clock edges. They also assume over_temp, when used, stays high across at least one edge, so each leg state machine sees it. The bench drives every input at the falling edge, holds each pulse for whole cycles, and samples just before the next drive. It sweeps all sixteen mode-to-mode transitions and computes each expected gate from the mode table and the dead-time latency. Fault pulses are sized at QUAL_CYC-1 and QUAL_CYC cycles on a small configuration.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

   localparam int NLEG = 2;

   // fault channel map
   localparam int FLT_SRC  = 0;           // NLEG source overcurrent channels
   localparam int FLT_SNK  = FLT_SRC + NLEG;
   localparam int FLT_OPEN = FLT_SNK + NLEG;
   localparam int FLT_LOAD = FLT_OPEN + 1;
   localparam int NFLT     = FLT_LOAD + 1;

   typedef enum logic [1:0] {
      LEG_FLOAT = 2'd0,
      LEG_SRC   = 2'd1,
      LEG_SNK   = 2'd2
   } leg_cmd_e;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_WAIT = 2'd1,
      ST_SRC  = 2'd2,
      ST_SNK  = 2'd3
   } leg_st_e;

   // mode decode: what one leg is asked to do for the control pair
   function automatic leg_cmd_e leg_cmd(input logic a, input logic b, input int leg);
      leg_cmd_e r;
      case ({a, b})
         2'b00:   r = (leg == 0) ? LEG_SRC : LEG_SNK;
         2'b01:   r = (leg == 0) ? LEG_SNK : LEG_SRC;
         2'b10:   r = LEG_SNK;
         default: r = LEG_FLOAT;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/hbridge_qual.sv
module hbridge_qual #(
   parameter int QUAL_CYC = 4000
) (
   input  logic clk,
   input  logic rst,
   input  logic sense,
   input  logic armed,
   output logic hit
);
   localparam int CW = (QUAL_CYC > 2) ? $clog2(QUAL_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

   logic [CW-1:0] cnt;
   logic          live;

   assign live = sense && armed;

   always_ff @(posedge clk) begin
      if (rst || !live)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign hit = live && (cnt == LAST);

   assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);

   assert_cnt_restart_R3: assert property (@(posedge clk) disable iff (rst)
      !live |=> (cnt == '0));

endmodule

// File: rtl/hbridge_leg.sv
module hbridge_leg
   import hbridge_pkg::*;
#(
   parameter int DEAD_CYC = 8
) (
   input  logic     clk,
   input  logic     rst,
   input  leg_cmd_e want,
   input  logic     kill,
   output logic     gate_src,
   output logic     gate_snk
);
   localparam int DW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;
   localparam logic [DW-1:0] DLAST = DW'(DEAD_CYC - 1);

   leg_st_e       st;
   leg_cmd_e      tgt;
   leg_cmd_e      eff;
   logic [DW-1:0] cnt;

   assign eff = kill ? LEG_FLOAT : want;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= ST_OFF;
         tgt <= LEG_FLOAT;
         cnt <= '0;
      end else begin
         case (st)
            ST_OFF: begin
               if (eff != LEG_FLOAT) begin
                  st  <= ST_WAIT;
                  tgt <= eff;
                  cnt <= '0;
               end
            end
            ST_WAIT: begin
               if (eff != tgt)
                  st <= ST_OFF;
               else if (cnt == DLAST)
                  st <= (tgt == LEG_SRC) ? ST_SRC : ST_SNK;
               else
                  cnt <= cnt + 1'b1;
            end
            ST_SRC: if (eff != LEG_SRC) st <= ST_OFF;
            ST_SNK: if (eff != LEG_SNK) st <= ST_OFF;
            default: st <= ST_OFF;
         endcase
      end
   end

   // masking lets a shutdown drop the gates in the cycle the flag falls
   assign gate_src = (st == ST_SRC) && !kill;
   assign gate_snk = (st == ST_SNK) && !kill;

   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
      !(gate_src && gate_snk));

   assert_src_gap_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_src) |-> $past(!gate_snk));

   assert_snk_gap_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_snk) |-> $past(!gate_src));

endmodule

// File: rtl/hbridge_fault.sv
module hbridge_fault
   import hbridge_pkg::*;
#(
   parameter int QUAL_CYC = 4000
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ctl_a,
   input  logic            ctl_b,
   input  logic [NLEG-1:0] oc_src,
   input  logic [NLEG-1:0] oc_snk,
   input  logic            load_short,
   input  logic            open_hi,
   input  logic            open_lo,
   input  logic            over_temp,
   input  logic            uv_on,
   input  logic            uv_off,
   output logic            kill,
   output logic            err_od
);
   logic [1:0]      ctl_prev;
   logic            chg;
   logic            sup_ok;
   logic            uv_flag;
   logic            watch;
   logic            trip;
   logic [NFLT-1:0] sense;
   logic [NFLT-1:0] arm;
   logic [NFLT-1:0] hit;
   logic [NFLT-1:0] lat;
   logic [NLEG-1:0] any_src;

   assign chg   = ({ctl_a, ctl_b} != ctl_prev);
   assign watch = sup_ok && !over_temp;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_prev <= 2'b11;
         sup_ok   <= 1'b0;
         uv_flag  <= 1'b0;
      end else begin
         ctl_prev <= {ctl_a, ctl_b};
         if (uv_off) begin
            sup_ok  <= 1'b0;
            uv_flag <= 1'b1;
         end else if (uv_on) begin
            sup_ok  <= 1'b1;
            uv_flag <= 1'b0;
         end
      end
   end

   // per-leg channels: arming follows the commanded switch
   for (genvar i = 0; i < NLEG; i++) begin : g_leg_arm
      leg_cmd_e c;
      assign c                 = leg_cmd(ctl_a, ctl_b, i);
      assign any_src[i]        = (c == LEG_SRC);
      assign arm[FLT_SRC + i]  = watch && (c == LEG_SRC);
      assign arm[FLT_SNK + i]  = watch && (c == LEG_SNK);
      assign sense[FLT_SRC + i] = oc_src[i];
      assign sense[FLT_SNK + i] = oc_snk[i];
   end

   assign arm[FLT_OPEN]   = watch && ctl_a && ctl_b;
   assign sense[FLT_OPEN] = open_hi && open_lo;
   assign arm[FLT_LOAD]   = watch && (|any_src);
   assign sense[FLT_LOAD] = load_short;

   for (genvar c = 0; c < NFLT; c++) begin : g_chan
      hbridge_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
         .clk   (clk),
         .rst   (rst),
         .sense (sense[c]),
         .armed (arm[c]),
         .hit   (hit[c])
      );

      if (c == FLT_LOAD) begin : g_sticky
         always_ff @(posedge clk) begin
            if (rst || uv_off || !sup_ok)
               lat[c] <= 1'b0;
            else if (hit[c])
               lat[c] <= 1'b1;
         end
      end else begin : g_toggle
         always_ff @(posedge clk) begin
            if (rst)
               lat[c] <= 1'b0;
            else if (hit[c])
               lat[c] <= 1'b1;
            else if (chg && !arm[c])
               lat[c] <= 1'b0;
         end
      end

      assert_set_needs_sense_R3: assert property (@(posedge clk) disable iff (rst)
         $rose(lat[c]) |-> $past(sense[c] && arm[c]));
   end

   assign trip   = |lat;
   assign kill   = trip || over_temp || !sup_ok;
   assign err_od = trip || over_temp || uv_flag;

   assert_open_mode_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(lat[FLT_OPEN]) |-> $past(ctl_a && ctl_b));

   assert_load_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (lat[FLT_LOAD] && !uv_off) |=> lat[FLT_LOAD]);

   assert_uv_flag_R9: assert property (@(posedge clk) disable iff (rst)
      uv_off |=> (uv_flag && !sup_ok));

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
   import hbridge_pkg::*;
#(
   parameter int QUAL_CYC = 4000,
   parameter int DEAD_CYC = 8
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ctl_a,
   input  logic       ctl_b,
   input  logic [1:0] oc_src,
   input  logic [1:0] oc_snk,
   input  logic       load_short,
   input  logic       open_hi,
   input  logic       open_lo,
   input  logic       over_temp,
   input  logic       uv_on,
   input  logic       uv_off,
   output logic [1:0] gate_src,
   output logic [1:0] gate_snk,
   output logic       err_od,
   output logic       err_n
);
   if (QUAL_CYC < 2) begin : g_bad_qual
      $error("QUAL_CYC must be at least 2");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (NLEG != 2) begin : g_bad_leg
      $error("bridge needs exactly two legs");
   end

   logic kill;

   hbridge_fault #(.QUAL_CYC(QUAL_CYC)) u_fault (
      .clk        (clk),
      .rst        (rst),
      .ctl_a      (ctl_a),
      .ctl_b      (ctl_b),
      .oc_src     (oc_src),
      .oc_snk     (oc_snk),
      .load_short (load_short),
      .open_hi    (open_hi),
      .open_lo    (open_lo),
      .over_temp  (over_temp),
      .uv_on      (uv_on),
      .uv_off     (uv_off),
      .kill       (kill),
      .err_od     (err_od)
   );

   for (genvar i = 0; i < NLEG; i++) begin : g_leg
      leg_cmd_e want;
      assign want = leg_cmd(ctl_a, ctl_b, i);

      hbridge_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
         .clk      (clk),
         .rst      (rst),
         .want     (want),
         .kill     (kill),
         .gate_src (gate_src[i]),
         .gate_snk (gate_snk[i])
      );
   end

   assign err_n = !err_od;

   assert_off_on_err_R4: assert property (@(posedge clk) disable iff (rst)
      err_od |-> (gate_src == 2'b00 && gate_snk == 2'b00));

   assert_uv_off_R9: assert property (@(posedge clk) disable iff (rst)
      uv_off |=> (gate_src == 2'b00 && gate_snk == 2'b00 && err_od));

   assert_heat_R8: assert property (@(posedge clk) disable iff (rst)
      over_temp |-> (err_od && gate_src == 2'b00 && gate_snk == 2'b00));

endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int QUAL = 5;
   localparam int DEAD = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ctl_a = 1'b0, ctl_b = 1'b0;
   logic [1:0] oc_src = '0, oc_snk = '0;
   logic       load_short = 1'b0, open_hi = 1'b0, open_lo = 1'b0;
   logic       over_temp = 1'b0, uv_on = 1'b0, uv_off = 1'b0;
   logic [1:0] gate_src, gate_snk;
   logic       err_od, err_n;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_ctrl #(.QUAL_CYC(QUAL), .DEAD_CYC(DEAD)) u_dut (
      .clk(clk), .rst(rst), .ctl_a(ctl_a), .ctl_b(ctl_b),
      .oc_src(oc_src), .oc_snk(oc_snk), .load_short(load_short),
      .open_hi(open_hi), .open_lo(open_lo), .over_temp(over_temp),
      .uv_on(uv_on), .uv_off(uv_off), .gate_src(gate_src),
      .gate_snk(gate_snk), .err_od(err_od), .err_n(err_n)
   );

   // leg command from the mode table: 0 off, 1 source, 2 sink
   function automatic int want(input int pat, input int leg);
      case (pat)
         0: return (leg == 0) ? 1 : 2;
         1: return (leg == 0) ? 2 : 1;
         2: return 2;
         default: return 0;
      endcase
   endfunction

   // settled view {err_n, src[1:0], snk[1:0]} with no fault
   function automatic logic [4:0] settled(input int pat);
      logic [1:0] s, k;
      for (int l = 0; l < 2; l++) begin
         s[l] = (want(pat, l) == 1);
         k[l] = (want(pat, l) == 2);
      end
      return {1'b1, s, k};
   endfunction

   task automatic chk(input string req, input logic [4:0] exp);
      logic [4:0] act;
      act = {err_n, gate_src, gate_snk};
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setp(input int pat);
      ctl_a = pat[1];
      ctl_b = pat[0];
   endtask

   task automatic pulse_on();
      uv_on = 1'b1; cyc(1); uv_on = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      setp(0);
      cyc(3);
      rst = 1'b0;
      cyc(1);
      chk("R10 reset state", 5'b1_00_00);
      cyc(5);
      chk("R9 no drive before uv_on", 5'b1_00_00);
      pulse_on();
      cyc(10);
      chk("R9 drive after uv_on", settled(0));

      // R1 R2 full transition sweep
      for (int f = 0; f < 4; f++) begin
         for (int t = 0; t < 4; t++) begin
            setp(f);
            cyc(12);
            chk("R1 settled mode", settled(f));
            setp(t);
            for (int k = 1; k <= 6; k++) begin
               logic [1:0] s, n;
               cyc(1);
               for (int l = 0; l < 2; l++) begin
                  int o, w, lat;
                  o = want(f, l);
                  w = want(t, l);
                  lat = (o == w) ? 0 : (o == 0) ? DEAD + 1 : DEAD + 2;
                  s[l] = (w == 1) && (k >= lat);
                  n[l] = (w == 2) && (k >= lat);
               end
               chk("R2 dead-time sequence", {1'b1, s, n});
            end
         end
      end

      // R3 short pulses ignored, R4 shutdown at QUAL
      setp(0);
      cyc(12);
      oc_src = 2'b01; cyc(QUAL - 1); oc_src = 2'b00; cyc(2);
      chk("R3 pulse of QUAL-1 ignored", settled(0));
      for (int r = 0; r < 4; r++) begin
         oc_snk = 2'b10; cyc(3); oc_snk = 2'b00; cyc(1);
      end
      chk("R3 repeated glitches ignored", settled(0));
      oc_src = 2'b01; cyc(QUAL - 1);
      chk("R3 not yet latched", settled(0));
      cyc(1);
      chk("R4 shutdown and flag", 5'b0_00_00);
      chk("R4 open-drain enable", {~err_od, gate_src, gate_snk});
      setp(2);
      cyc(1);
      chk("R5 cleared by non-detecting mode", 5'b1_00_00);
      oc_src = 2'b00;
      cyc(10);
      chk("R5 brake after clear", settled(2));

      // R5 mode still commanding the switch keeps the latch
      setp(1);
      cyc(12);
      oc_snk = 2'b01; cyc(QUAL);
      chk("R4 sink overcurrent latched", 5'b0_00_00);
      oc_snk = 2'b00; setp(2); cyc(3);
      chk("R5 stays latched in brake", 5'b0_00_00);
      setp(0); cyc(1);
      chk("R5 clears leaving sink", 5'b1_00_00);
      cyc(10);
      chk("R5 drive resumes", settled(0));

      // R5 unwatched switch
      setp(3); cyc(2);
      oc_src = 2'b01; cyc(10);
      chk("R5 unwatched overcurrent ignored", 5'b1_00_00);
      oc_src = 2'b00; setp(0); cyc(12);

      // R6 load short
      load_short = 1'b1; cyc(QUAL);
      chk("R6 load short latched", 5'b0_00_00);
      load_short = 1'b0; setp(3); cyc(3);
      chk("R6 held through float", 5'b0_00_00);
      setp(2); cyc(3);
      chk("R6 held through brake", 5'b0_00_00);
      uv_off = 1'b1; cyc(1); uv_off = 1'b0;
      chk("R9 uv_off flags", 5'b0_00_00);
      cyc(3);
      chk("R9 undervoltage holds off", 5'b0_00_00);
      pulse_on();
      chk("R6 cleared by undervoltage", 5'b1_00_00);
      cyc(10);
      chk("R9 recovery after uv_on", settled(2));

      // R7 open load
      setp(3); cyc(3);
      open_hi = 1'b1; cyc(10);
      chk("R7 one comparator ignored", 5'b1_00_00);
      open_lo = 1'b1; cyc(QUAL);
      chk("R7 open load latched", 5'b0_00_00);
      open_hi = 1'b0; open_lo = 1'b0; setp(0); cyc(1);
      chk("R7 cleared by mode change", 5'b1_00_00);
      cyc(10);
      open_hi = 1'b1; open_lo = 1'b1; cyc(10);
      chk("R7 unwatched while driving", settled(0));
      open_hi = 1'b0; open_lo = 1'b0;

      // R8 overtemperature
      over_temp = 1'b1; cyc(1);
      chk("R8 heat shutdown", 5'b0_00_00);
      cyc(5);
      chk("R8 heat held", 5'b0_00_00);
      over_temp = 1'b0; cyc(1);
      chk("R8 flag released", 5'b1_00_00);
      cyc(10);
      chk("R8 drive recovers", settled(0));

      // R9 both supply levels together
      uv_on = 1'b1; uv_off = 1'b1; cyc(1); uv_on = 1'b0; uv_off = 1'b0;
      chk("R9 uv_off wins", 5'b0_00_00);
      cyc(3);
      chk("R9 still off", 5'b0_00_00);
      pulse_on();
      cyc(10);
      chk("R9 drive after second uv_on", settled(0));

      // R10 reset clears a sticky latch
      load_short = 1'b1; cyc(QUAL);
      chk("R6 load short again", 5'b0_00_00);
      load_short = 1'b0; rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
      chk("R10 reset clears latch", 5'b1_00_00);
      cyc(5);
      chk("R10 no drive without uv_on", 5'b1_00_00);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule